// File: doc/BRIEF.md
# Page-Translating DMA Channel

A single DMA channel that moves a byte stream between a peripheral and system memory. The buffer seen by the peripheral is logically contiguous. Physically it may be scattered, one 4 KiB page at a time. Each logical address is mapped through a table of 8-byte entries kept in memory. The channel fetches an entry with a 4-byte read on its memory master port. It keeps the most recent translation, so a new fetch happens only when the logical address enters a different page. It then issues data bursts to the translated physical address.

Software programs six registers: mode, enable, byte count, logical start, table base and table limit. Setting the run bit arms the channel. A peripheral then raises a transfer request with a direction and a length in bytes. If the direction matches the programmed direction bit, bytes move one per handshake until either the count window or the requested length runs out. At the end the count register is cleared and a one-cycle done pulse is raised. A request in the wrong direction is refused with a one-cycle reject pulse and moves nothing.

Top module: `xlat_dma_channel`

## Requirements
- R1: After reset all six registers read zero, no memory command is issued, and the done and reject outputs are low.
- R2: Registers are written and read back at these byte offsets: mode 0x00, enable 0x08, count 0x10, logical start 0x18, table base 0x20, table limit 0x28. In the enable register, bit 0 is the run bit and bit 1 is the direction bit (1 = memory to device).
- R3: While the run bit is clear, a transfer request is ignored: there is no memory command, no done pulse, no reject pulse, and the count register is unchanged.
- R4: A request whose direction input differs from the direction bit produces a one-cycle reject pulse. No memory command is issued and the count register is unchanged.
- R5: A translation fetch is a table command (mem_tbl_o=1) with burst length 4, at address table_base + (logical_addr >> 12) * 8.
- R6: The physical address is the table entry with its low 12 bits cleared, plus the low 12 bits of the logical address. When cfg_big_endian_i=0, mem_rdata_i[7:0] is the least significant entry byte. When cfg_big_endian_i=1, mem_rdata_i[7:0] is the most significant entry byte.
- R7: Within a transfer, a table fetch happens for the first page touched and on each move into a different page, and at no other time.
- R8: Let rem be the smaller of the remaining requested bytes and the bytes left in the window start+count. A data command has burst length 256 if the physical address is 256-byte aligned and rem ≥ 256; otherwise 16 if it is 16-byte aligned and rem ≥ 16; otherwise 1.
- R9: The transfer stops when the logical address reaches start+count or the requested length has been moved, whichever comes first. A zero count moves nothing.
- R10: At the end of an accepted transfer, the count register reads zero and xfer_done_o pulses for exactly one cycle.
- R11: A byte moves when mem_beat_rdy_i is high together with dev_ready_i (memory to device) or dev_valid_i (device to memory). In the memory-to-device direction, dev_data_o carries mem_rdata_i[7:0]. In the device-to-memory direction, mem_wdata_o carries dev_data_i and the data command has mem_we_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_big_endian_i | input | 1 | Byte order of table entries |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| xfer_req_i | input | 1 | Transfer request pulse |
| xfer_to_dev_i | input | 1 | Requested direction, 1 = memory to device |
| xfer_len_i | input | 16 | Requested byte length |
| xfer_done_o | output | 1 | End-of-transfer pulse |
| xfer_rej_o | output | 1 | Direction-mismatch pulse |
| mem_req_o | output | 1 | Memory command valid |
| mem_tbl_o | output | 1 | Command is a table-entry read |
| mem_we_o | output | 1 | Command writes memory |
| mem_addr_o | output | 32 | Command address |
| mem_blen_o | output | 9 | Command burst length in bytes |
| mem_gnt_i | input | 1 | Command accepted |
| mem_rvalid_i | input | 1 | Table entry data valid |
| mem_rdata_i | input | 32 | Table entry, or read byte in [7:0] |
| mem_beat_rdy_i | input | 1 | Memory ready for one data byte |
| mem_beat_o | output | 1 | One data byte moved this cycle |
| mem_wdata_o | output | 8 | Byte written to memory |
| dev_valid_o | output | 1 | Byte offered to the device |
| dev_ready_i | input | 1 | Device accepts a byte |
| dev_data_o | output | 8 | Byte to the device |
| dev_valid_i | input | 1 | Device offers a byte |
| dev_ready_o | output | 1 | Channel accepts a device byte |
| dev_data_i | input | 8 | Byte from the device |

## Verification
The bench uses a buffer that starts four bytes before a page boundary. A design that fetched once per transfer, or on every burst, would show the wrong number of table reads. One that ignored the page boundary would send bytes to the old physical page. A big-endian run in which memory stalls the data beats and the command grants catches a channel that assembles the entry in the wrong byte order: every data command would land at a scrambled physical page. It also catches one that loses a byte under back-pressure. A 256-aligned run with a short tail, plus a run where the length is shorter than the count, expose burst sizing that reads past the window or stops on the wrong limit. Wrong-direction and not-running requests check that nothing leaks onto the memory port and that the count survives.

// File: rtl/xdma_pkg.sv
`timescale 1ns/1ps
package xdma_pkg;
  localparam logic [5:0] OFF_MODE  = 6'h00;
  localparam logic [5:0] OFF_ENAB  = 6'h08;
  localparam logic [5:0] OFF_COUNT = 6'h10;
  localparam logic [5:0] OFF_START = 6'h18;
  localparam logic [5:0] OFF_TBASE = 6'h20;
  localparam logic [5:0] OFF_TLIM  = 6'h28;
  localparam int EN_RUN_BIT   = 0;
  localparam int EN_TODEV_BIT = 1;
  localparam int PG_LG        = 12;
  localparam int ENT_LG       = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_TREQ, ST_TWAIT, ST_CMD, ST_DATA
  } chan_st_e;
endpackage

// File: rtl/xdma_regs.sv
`timescale 1ns/1ps
module xdma_regs
  import xdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [5:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          cnt_clr_i,
  output logic [AW-1:0] rdata_o,
  output logic          run_o,
  output logic          to_dev_o,
  output logic [AW-1:0] count_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] tbase_o
);
  logic [AW-1:0] mode_q, enab_q, count_q, start_q, tbase_q, tlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      enab_q  <= '0;
      count_q <= '0;
      start_q <= '0;
      tbase_q <= '0;
      tlim_q  <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          OFF_MODE:  mode_q  <= wdata_i;
          OFF_ENAB:  enab_q  <= wdata_i;
          OFF_COUNT: count_q <= wdata_i;
          OFF_START: start_q <= wdata_i;
          OFF_TBASE: tbase_q <= wdata_i;
          OFF_TLIM:  tlim_q  <= wdata_i;
          default: ;
        endcase
      end
      // end-of-transfer clear wins over a same-cycle write
      if (cnt_clr_i) count_q <= '0;
    end
  end

  always_comb begin
    case (addr_i)
      OFF_MODE:  rdata_o = mode_q;
      OFF_ENAB:  rdata_o = enab_q;
      OFF_COUNT: rdata_o = count_q;
      OFF_START: rdata_o = start_q;
      OFF_TBASE: rdata_o = tbase_q;
      OFF_TLIM:  rdata_o = tlim_q;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o    = enab_q[EN_RUN_BIT];
  assign to_dev_o = enab_q[EN_TODEV_BIT];
  assign count_o  = count_q;
  assign start_o  = start_q;
  assign tbase_o  = tbase_q;

  assert_count_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (count_q == '0));
endmodule

// File: rtl/xdma_xlat.sv
`timescale 1ns/1ps
module xdma_xlat
  import xdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inval_i,
  input  logic          load_i,
  input  logic          big_i,
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] laddr_i,
  output logic          hit_o,
  output logic [AW-1:0] phys_o
);
  localparam int NBYTE = AW / 8;
  localparam int PW    = AW - PG_LG;

  logic [AW-1:0] ent_swp, ent;
  logic [PW-1:0] tag_q, base_q;
  logic          vld_q;

  always_comb begin
    for (int b = 0; b < NBYTE; b++)
      ent_swp[b*8 +: 8] = entry_i[(NBYTE-1-b)*8 +: 8];
  end
  assign ent = big_i ? ent_swp : entry_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      base_q <= '0;
    end else if (inval_i) begin
      vld_q <= 1'b0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      tag_q  <= laddr_i[AW-1:PG_LG];
      base_q <= ent[AW-1:PG_LG];
    end
  end

  assign hit_o  = vld_q && (tag_q == laddr_i[AW-1:PG_LG]);
  assign phys_o = {base_q, laddr_i[PG_LG-1:0]};

  assert_load_then_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !inval_i) |=> (hit_o || !$stable(laddr_i)));
endmodule

// File: rtl/xdma_burst.sv
`timescale 1ns/1ps
module xdma_burst #(
  parameter int RW  = 33,
  parameter int SLG = 4,
  parameter int BLG = 8
) (
  input  logic [BLG-1:0] off_i,
  input  logic [RW-1:0]  rem_i,
  output logic [BLG:0]   blen_o
);
  localparam logic [RW-1:0] SMALL = RW'(1) << SLG;
  localparam logic [RW-1:0] BIG   = RW'(1) << BLG;

  always_comb begin
    blen_o = (BLG+1)'(1);
    if (off_i[SLG-1:0] == '0 && rem_i >= SMALL) blen_o = (BLG+1)'(1) << SLG;
    if (off_i == '0 && rem_i >= BIG)            blen_o = (BLG+1)'(1) << BLG;
  end
endmodule

// File: rtl/xlat_dma_channel.sv
`timescale 1ns/1ps
module xlat_dma_channel
  import xdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int SLG = 4,
  parameter int BLG = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_big_endian_i,
  input  logic          reg_wr_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          xfer_req_i,
  input  logic          xfer_to_dev_i,
  input  logic [LW-1:0] xfer_len_i,
  output logic          xfer_done_o,
  output logic          xfer_rej_o,
  output logic          mem_req_o,
  output logic          mem_tbl_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BLG:0]  mem_blen_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_beat_rdy_i,
  output logic          mem_beat_o,
  output logic [7:0]    mem_wdata_o,
  output logic          dev_valid_o,
  input  logic          dev_ready_i,
  output logic [7:0]    dev_data_o,
  input  logic          dev_valid_i,
  output logic          dev_ready_o,
  input  logic [7:0]    dev_data_i
);
  localparam int AW1 = AW + 1;
  localparam logic [BLG:0] TBL_BLEN = (BLG+1)'(4);

  chan_st_e      st_q;
  logic          run, to_dev_reg, hit, start_go, cnt_clr, ent_load, fire, in_range;
  logic [AW-1:0] count_w, start_w, tbase_w, phys, tbl_addr, laddr_q;
  logic [AW1-1:0] end_q, rem_len, rem_cnt, rem;
  logic [LW-1:0] len_q, moved_q;
  logic [BLG:0]  beats_q, blen;
  logic          to_dev_q, done_q, rej_q;

  xdma_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_clr_i(cnt_clr), .rdata_o(reg_rdata_o),
    .run_o(run), .to_dev_o(to_dev_reg),
    .count_o(count_w), .start_o(start_w), .tbase_o(tbase_w)
  );

  xdma_xlat #(.AW(AW)) u_xlat (
    .clk_i, .rst_ni,
    .inval_i(start_go), .load_i(ent_load), .big_i(cfg_big_endian_i),
    .entry_i(mem_rdata_i), .laddr_i(laddr_q),
    .hit_o(hit), .phys_o(phys)
  );

  xdma_burst #(.RW(AW1), .SLG(SLG), .BLG(BLG)) u_burst (
    .off_i(phys[BLG-1:0]), .rem_i(rem), .blen_o(blen)
  );

  assign in_range = ({1'b0, laddr_q} < end_q) && (moved_q < len_q);
  assign rem_len  = AW1'(len_q - moved_q);
  assign rem_cnt  = end_q - {1'b0, laddr_q};
  assign rem      = (rem_len < rem_cnt) ? rem_len : rem_cnt;
  assign tbl_addr = tbase_w + AW'({laddr_q[AW-1:PG_LG], {ENT_LG{1'b0}}});

  assign start_go = (st_q == ST_IDLE) && xfer_req_i && run && (xfer_to_dev_i == to_dev_reg);
  assign cnt_clr  = (st_q == ST_NEXT) && !in_range;
  assign ent_load = (st_q == ST_TWAIT) && mem_rvalid_i;
  assign fire     = (st_q == ST_DATA) && mem_beat_rdy_i && (to_dev_q ? dev_ready_i : dev_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      end_q    <= '0;
      laddr_q  <= '0;
      len_q    <= '0;
      moved_q  <= '0;
      beats_q  <= '0;
      to_dev_q <= 1'b0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (xfer_req_i && run) begin
            if (xfer_to_dev_i != to_dev_reg) begin
              rej_q <= 1'b1;
            end else begin
              end_q    <= {1'b0, start_w} + {1'b0, count_w};
              laddr_q  <= start_w;
              len_q    <= xfer_len_i;
              moved_q  <= '0;
              to_dev_q <= xfer_to_dev_i;
              st_q     <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (!in_range) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (hit) begin
            st_q <= ST_CMD;
          end else begin
            st_q <= ST_TREQ;
          end
        end
        ST_TREQ:  if (mem_gnt_i) st_q <= ST_TWAIT;
        ST_TWAIT: if (mem_rvalid_i) st_q <= ST_CMD;
        ST_CMD: begin
          if (mem_gnt_i) begin
            beats_q <= blen;
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (fire) begin
            laddr_q <= laddr_q + AW'(1);
            moved_q <= moved_q + LW'(1);
            beats_q <= beats_q - (BLG+1)'(1);
            if (beats_q == (BLG+1)'(1)) st_q <= ST_NEXT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_TREQ) || (st_q == ST_CMD);
  assign mem_tbl_o   = (st_q == ST_TREQ);
  assign mem_we_o    = (st_q == ST_CMD) && !to_dev_q;
  assign mem_addr_o  = (st_q == ST_TREQ) ? tbl_addr : phys;
  assign mem_blen_o  = (st_q == ST_TREQ) ? TBL_BLEN : blen;
  assign mem_beat_o  = fire;
  assign mem_wdata_o = dev_data_i;
  assign dev_data_o  = mem_rdata_i[7:0];
  assign dev_valid_o = (st_q == ST_DATA) && to_dev_q && mem_beat_rdy_i;
  assign dev_ready_o = (st_q == ST_DATA) && !to_dev_q && mem_beat_rdy_i;
  assign xfer_done_o = done_q;
  assign xfer_rej_o  = rej_q;

  assert_cmd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_tbl_o)));
  assert_big_burst_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_tbl_o && mem_blen_o == ((BLG+1)'(1) << BLG)) |-> (mem_addr_o[BLG-1:0] == '0));
  assert_never_past_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moved_q <= len_q));
  assert_done_count_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> (count_w == '0));
  assert_reject_no_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_rej_o |-> !mem_req_o);
endmodule

// File: tb/xlat_dma_channel_test.sv
`timescale 1ns/1ps
module xlat_dma_channel_test;
  logic        clk = 0, rst_n = 0;
  logic        big = 0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        xreq = 0, xtodev = 0;
  logic [15:0] xlen = 0;
  logic        done, rej;
  logic        mem_req, mem_tbl, mem_we, mem_gnt, mem_rvalid = 0, mem_beat_rdy, mem_beat;
  logic [31:0] mem_addr, mem_rdata, rword = 0;
  logic [8:0]  mem_blen;
  logic [7:0]  mem_wdata, dev_data_o, dev_data_i;
  logic        dev_valid_o, dev_ready_i, dev_valid_i, dev_ready_o;

  int checks = 0, fails = 0, cyc = 0;
  bit stall = 0, finished = 0;
  logic [31:0] tbase_tb = 0, bptr = 0;

  int nc = 0, nb = 0, ndone = 0, nrej = 0;
  logic [31:0] c_addr [0:63];
  logic [8:0]  c_len  [0:63];
  logic        c_tbl  [0:63];
  logic        c_we   [0:63];
  logic [7:0]  b_val  [0:511];
  logic [31:0] b_addr [0:511];

  int ne = 0, nbx = 0;
  logic [31:0] e_addr [0:63];
  logic [8:0]  e_len  [0:63];
  logic        e_tbl  [0:63];
  logic [31:0] eb_addr[0:511];

  always #2.5 clk = ~clk;

  xlat_dma_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_big_endian_i(big),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xfer_req_i(xreq), .xfer_to_dev_i(xtodev), .xfer_len_i(xlen),
    .xfer_done_o(done), .xfer_rej_o(rej),
    .mem_req_o(mem_req), .mem_tbl_o(mem_tbl), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_blen_o(mem_blen), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .mem_beat_rdy_i(mem_beat_rdy), .mem_beat_o(mem_beat), .mem_wdata_o(mem_wdata),
    .dev_valid_o(dev_valid_o), .dev_ready_i(dev_ready_i), .dev_data_o(dev_data_o),
    .dev_valid_i(dev_valid_i), .dev_ready_o(dev_ready_o), .dev_data_i(dev_data_i)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] ent(input logic [19:0] pg);
    return {pg * 20'd7 + 20'd3, 12'hABC};
  endfunction
  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign mem_gnt      = mem_req & (stall ? cyc[0] : 1'b1);
  assign mem_beat_rdy = stall ? (cyc[1:0] != 2'd0) : 1'b1;
  assign dev_ready_i  = stall ? (cyc[2:0] != 3'd5) : 1'b1;
  assign dev_valid_i  = stall ? (cyc[2:0] != 3'd3) : 1'b1;
  assign dev_data_i   = nb[7:0] ^ 8'hC3;
  assign mem_rdata    = mem_rvalid ? rword : {24'h0, pat(bptr)};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (rst_n) begin
      if (mem_req && mem_gnt) begin
        if (nc < 64) begin
          c_addr[nc] = mem_addr; c_len[nc] = mem_blen; c_tbl[nc] = mem_tbl; c_we[nc] = mem_we;
        end
        nc = nc + 1;
        if (mem_tbl) begin
          logic [31:0] pg;
          pg = (mem_addr - tbase_tb) >> 3;
          mem_rvalid <= 1'b1;
          rword <= big ? swap(ent(pg[19:0])) : ent(pg[19:0]);
        end else begin
          bptr <= mem_addr;
        end
      end
      if (mem_beat) begin
        if (nb < 512) begin
          b_val[nb]  = xtodev ? dev_data_o : mem_wdata;
          b_addr[nb] = bptr;
        end
        nb = nb + 1;
        bptr <= bptr + 1;
      end
      if (done) ndone = ndone + 1;
      if (rej)  nrej  = nrej + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] en, cnt, st, tb);
    wr(6'h08, en); wr(6'h10, cnt); wr(6'h18, st); wr(6'h20, tb);
    tbase_tb = tb;
  endtask

  task automatic request(input bit todev, input logic [15:0] len, input int wait_max);
    @(negedge clk);
    nc = 0; nb = 0; ndone = 0; nrej = 0;
    xtodev = todev; xlen = len; xreq = 1;
    @(negedge clk); xreq = 0;
    for (int i = 0; i < wait_max; i++) begin
      if (ndone != 0 || nrej != 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic model(input logic [31:0] st, cnt, tb, input int len);
    logic [32:0] endv, la;
    logic [19:0] tag;
    logic [31:0] pb, ph, r;
    int moved, bl;
    bit vld;
    endv = {1'b0, st} + {1'b0, cnt}; la = {1'b0, st}; moved = 0; vld = 0; ne = 0; nbx = 0;
    tag = 0; pb = 0;
    while (la < endv && moved < len) begin
      if (!vld || tag != la[31:12]) begin
        e_addr[ne] = tb + {9'b0, la[31:12], 3'b0}; e_len[ne] = 9'd4; e_tbl[ne] = 1; ne++;
        vld = 1; tag = la[31:12]; pb = ent(tag) & 32'hFFFF_F000;
      end
      ph = pb | {20'b0, la[11:0]};
      r = ((len - moved) < (endv - la)) ? 32'(len - moved) : 32'(endv - la);
      bl = 1;
      if (ph[3:0] == 0 && r >= 16) bl = 16;
      if (ph[7:0] == 0 && r >= 256) bl = 256;
      e_addr[ne] = ph; e_len[ne] = 9'(bl); e_tbl[ne] = 0; ne++;
      for (int k = 0; k < bl; k++) begin eb_addr[nbx] = ph + k; nbx++; end
      la = la + 33'(bl); moved = moved + bl;
    end
  endtask

  task automatic compare(input bit todev);
    logic [31:0] c;
    chk(nc == ne, "R7 command count", nc, ne);
    for (int i = 0; i < ne && i < nc; i++) begin
      chk(c_tbl[i] == e_tbl[i], "R7 fetch placement", {31'b0, c_tbl[i]}, {31'b0, e_tbl[i]});
      chk(c_addr[i] == e_addr[i], e_tbl[i] ? "R5 table address" : "R6 physical address", c_addr[i], e_addr[i]);
      chk(c_len[i] == e_len[i], e_tbl[i] ? "R5 table burst" : "R8 burst length", {23'b0, c_len[i]}, {23'b0, e_len[i]});
      if (!e_tbl[i]) chk(c_we[i] == !todev, "R11 write flag", {31'b0, c_we[i]}, {31'b0, !todev});
    end
    chk(nb == nbx, "R9 bytes moved", nb, nbx);
    for (int k = 0; k < nbx && k < nb; k++) begin
      chk(b_addr[k] == eb_addr[k], "R6 byte address", b_addr[k], eb_addr[k]);
      chk(b_val[k] == (todev ? pat(eb_addr[k]) : (8'(k) ^ 8'hC3)), "R11 byte value",
          {24'b0, b_val[k]}, {24'b0, todev ? pat(eb_addr[k]) : (8'(k) ^ 8'hC3)});
    end
    chk(ndone == 1, "R10 one done pulse", ndone, 1);
    rd(6'h10, c);
    chk(c == 0, "R10 count cleared", c, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(6'(a * 8), d);
      chk(d == 0, "R1 register reset", d, 0);
    end
    chk(!mem_req && !done && !rej, "R1 idle outputs", {29'b0, mem_req, done, rej}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) wr(6'(a * 8), 32'h1000_0000 * (a + 1) + 32'h0123 * a + 1);
    for (int a = 0; a < 6; a++) begin
      rd(6'(a * 8), d);
      chk(d == 32'h1000_0000 * (a + 1) + 32'h0123 * a + 1, "R2 register readback", d,
          32'h1000_0000 * (a + 1) + 32'h0123 * a + 1);
    end
  endtask

  task automatic t_run_off;
    logic [31:0] d;
    setup(32'h2, 32'd50, 32'h1000, 32'h8000);
    request(1'b1, 16'd10, 20);
    chk(nc == 0, "R3 no memory command", nc, 0);
    chk(ndone == 0 && nrej == 0, "R3 no pulses", ndone + nrej, 0);
    rd(6'h10, d);
    chk(d == 50, "R3 count kept", d, 50);
  endtask

  task automatic t_reject;
    logic [31:0] d;
    setup(32'h3, 32'd60, 32'h1000, 32'h8000);
    request(1'b0, 16'd10, 50);
    chk(nrej == 1, "R4 reject pulse", nrej, 1);
    chk(nc == 0 && nb == 0, "R4 nothing moved", nc + nb, 0);
    rd(6'h10, d);
    chk(d == 60, "R4 count kept", d, 60);
  endtask

  task automatic t_page_cross;
    int nt = 0;
    big = 0; stall = 0;
    setup(32'h3, 32'd40, 32'h1FFC, 32'h8000);
    model(32'h1FFC, 32'd40, 32'h8000, 100);
    request(1'b1, 16'd100, 5000);
    for (int i = 0; i < nc && i < 64; i++) if (c_tbl[i]) nt++;
    chk(nt == 2, "R7 two page fetches", nt, 2);
    compare(1'b1);
  endtask

  task automatic t_big_write;
    big = 1; stall = 1;
    setup(32'h1, 32'h300, 32'h3000, 32'h4_0000);
    model(32'h3000, 32'h300, 32'h4_0000, 32'h120);
    request(1'b0, 16'h120, 20000);
    compare(1'b0);
    stall = 0; big = 0;
  endtask

  task automatic t_len_limit;
    setup(32'h3, 32'h1000, 32'h5008, 32'h9000);
    model(32'h5008, 32'h1000, 32'h9000, 20);
    request(1'b1, 16'd20, 5000);
    chk(nb == 20, "R9 length limits transfer", nb, 20);
    compare(1'b1);
  endtask

  task automatic t_zero_count;
    setup(32'h3, 32'd0, 32'h2000, 32'h8000);
    request(1'b1, 16'd30, 100);
    chk(nc == 0 && nb == 0, "R9 zero count moves nothing", nc + nb, 0);
    chk(ndone == 1, "R10 done on empty window", ndone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_run_off;
    t_reject;
    t_page_cross;
    t_big_write;
    t_len_limit;
    t_zero_count;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule